// File: doc/BRIEF.md
# Compare, Set-on-Condition and Loop Decision Unit

This unit resolves branch-style conditions for a small processor core. On each accepted operation it does one of three jobs. A compare subtracts one operand from the other and keeps only the four arithmetic flags that result. A set-on-condition tests a condition code against the incoming flags and returns a byte that is either all ones or all zeros. A counted loop decrements the count register and decides whether the back-edge branch is taken, optionally qualified by the zero flag.

Fetch and branch-target arithmetic belong to the surrounding pipeline. The pipeline presents one operation per cycle with `op_valid`. Results appear, registered, one cycle later with `out_valid`, and they hold until the next accepted operation. The flags bus packs CF in bit 0, ZF in bit 1, SF in bit 2 and OF in bit 3.

Top module: `cmpcc_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid`, `flags_out`, `set_byte`, `count_out` and `take_branch` are all zero.
- R2: `out_valid` is `op_valid` delayed by one clock. When `op_valid` is low, every result output keeps its previous value.
- R3: Opcode 1 (compare) puts the flags of `opnd_a - opnd_b` on `flags_out`. CF (bit 0) is the unsigned borrow, ZF (bit 1) is set when the difference is zero, SF (bit 2) is the top bit of the difference, and OF (bit 3) is two's-complement overflow. The difference itself is not output. `count_out` equals `count_in`, `set_byte` is zero and `take_branch` is low.
- R4: The condition codes and their truth conditions are: 0 ZF, 1 !ZF, 2 CF, 3 CF|ZF, 4 !CF&!ZF, 5 !CF, 6 SF!=OF, 7 ZF|(SF!=OF), 8 !ZF&(SF==OF), 9 SF==OF. Codes 10 to 15 are never true.
- R5: Opcode 2 (set) gives `set_byte` all ones when the selected condition holds on `flags_in` and all zeros otherwise. `flags_out` equals `flags_in` and `count_out` equals `count_in`.
- R6: Opcode 3 (plain loop) gives `count_out = count_in - 1`. `take_branch` is high exactly when that new count is non-zero.
- R7: Opcode 4 (loop while equal) decrements like R6. It takes the branch only when the new count is non-zero and `flags_in` ZF is 1.
- R8: Opcode 5 (loop while not equal) decrements like R6. It takes the branch only when the new count is non-zero and `flags_in` ZF is 0.
- R9: The loop opcodes 3, 4 and 5 pass `flags_in` to `flags_out` unchanged, and `set_byte` is zero.
- R10: A loop with `count_in` equal to zero wraps `count_out` to all ones. This count is non-zero, so it counts as such for the branch decision.
- R11: Opcodes 0, 6 and 7 give `flags_out = flags_in`, `count_out = count_in`, a zero `set_byte` and a low `take_branch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op | input | 3 | Opcode (0 none, 1 compare, 2 set, 3 loop, 4 loop-equal, 5 loop-not-equal) |
| cc | input | 4 | Condition code for set |
| opnd_a | input | DATA_W | Compare minuend |
| opnd_b | input | DATA_W | Compare subtrahend |
| flags_in | input | 4 | Current flags {OF,SF,ZF,CF} |
| count_in | input | CNT_W | Current count register |
| out_valid | output | 1 | Results below belong to last accepted operation |
| flags_out | output | 4 | Resulting flags |
| set_byte | output | SET_W | All-ones or all-zeros set result |
| count_out | output | CNT_W | Resulting count register |
| take_branch | output | 1 | Loop branch taken |

## Verification
The bench builds the unit with an 8-bit operand width, a 4-bit count and an 8-bit set result. With 8-bit operands, random draws often give equal operands, borrows and signed overflow, so every compare flag and every signed and unsigned condition is exercised at both polarities. With a 4-bit count, the cases where the count decrements to zero and where it wraps from zero to all ones come up often, next to directed runs of each corner.

// File: rtl/cmpcc_pkg.sv
package cmpcc_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CMP    = 3'd1,
    OP_SET    = 3'd2,
    OP_LOOP   = 3'd3,
    OP_LOOPE  = 3'd4,
    OP_LOOPNE = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,
    CC_NE = 4'd1,
    CC_B  = 4'd2,
    CC_BE = 4'd3,
    CC_A  = 4'd4,
    CC_AE = 4'd5,
    CC_L  = 4'd6,
    CC_LE = 4'd7,
    CC_G  = 4'd8,
    CC_GE = 4'd9
  } cc_e;

  localparam int FLAG_W = 4;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic cf;
  } flags_t;

  // Truth of a condition code over a flag set; unknown codes are false.
  function automatic logic cond_holds(input logic [3:0] code, input flags_t f);
    logic lt;
    lt = f.sf ^ f.of;
    case (code)
      CC_EQ:   return f.zf;
      CC_NE:   return !f.zf;
      CC_B:    return f.cf;
      CC_BE:   return f.cf | f.zf;
      CC_A:    return !(f.cf | f.zf);
      CC_AE:   return !f.cf;
      CC_L:    return lt;
      CC_LE:   return lt | f.zf;
      CC_G:    return !(lt | f.zf);
      CC_GE:   return !lt;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_loop_op(input logic [2:0] o);
    return (o == OP_LOOP) || (o == OP_LOOPE) || (o == OP_LOOPNE);
  endfunction

endpackage

// File: rtl/cmpcc_flag_gen.sv
module cmpcc_flag_gen #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output cmpcc_pkg::flags_t fl,
  output logic              borrow
);
  localparam int MSB = DW - 1;

  // Subtraction widened by one bit: the extra bit is the unsigned borrow.
  function automatic logic [DW:0] sub_wide(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic ovf_sub(input logic xs, input logic ys, input logic rs);
    return (xs ^ ys) & (rs ^ xs);
  endfunction

  logic [DW:0]   wide;
  logic [DW-1:0] diff;

  assign wide   = sub_wide(a, b);
  assign diff   = wide[DW-1:0];
  assign borrow = wide[DW];

  always_comb begin
    fl.cf = borrow;
    fl.zf = (diff == '0);
    fl.sf = diff[MSB];
    fl.of = ovf_sub(a[MSB], b[MSB], diff[MSB]);
  end
endmodule

// File: rtl/cmpcc_cond_eval.sv
module cmpcc_cond_eval #(
  parameter int SW = 8
) (
  input  logic [3:0]        cc,
  input  cmpcc_pkg::flags_t fl,
  output logic              hit,
  output logic [SW-1:0]     set_val
);
  assign hit = cmpcc_pkg::cond_holds(cc, fl);

  for (genvar g = 0; g < SW; g++) begin : g_fan
    assign set_val[g] = hit;
  end
endmodule

// File: rtl/cmpcc_loop_ctl.sv
module cmpcc_loop_ctl #(
  parameter int CW = 32
) (
  input  logic [2:0]    op,
  input  logic [CW-1:0] cnt,
  input  logic          zf,
  output logic          loop_op,
  output logic [CW-1:0] cnt_dec,
  output logic          cnt_live,
  output logic          take
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  function automatic logic [CW-1:0] dec_wrap(input logic [CW-1:0] v);
    return v - ONE;
  endfunction

  assign loop_op  = cmpcc_pkg::is_loop_op(op);
  assign cnt_dec  = dec_wrap(cnt);
  assign cnt_live = (cnt_dec != '0);

  always_comb begin
    case (op)
      cmpcc_pkg::OP_LOOP:   take = cnt_live;
      cmpcc_pkg::OP_LOOPE:  take = cnt_live & zf;
      cmpcc_pkg::OP_LOOPNE: take = cnt_live & !zf;
      default:              take = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpcc_unit.sv
module cmpcc_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int SET_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op,
  input  logic [3:0]        cc,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [3:0]        flags_in,
  input  logic [CNT_W-1:0]  count_in,
  output logic              out_valid,
  output logic [3:0]        flags_out,
  output logic [SET_W-1:0]  set_byte,
  output logic [CNT_W-1:0]  count_out,
  output logic              take_branch
);
  import cmpcc_pkg::*;

  flags_t             fl_in;
  flags_t             cmp_fl;
  logic               cmp_borrow;
  logic               cond_hit;
  logic [SET_W-1:0]   set_val;
  logic               loop_op;
  logic [CNT_W-1:0]   cnt_dec;
  logic               cnt_live;
  logic               loop_take;

  // Named internal events
  logic               ev_cmp;
  logic               ev_set;

  flags_t             fl_nx;
  logic [SET_W-1:0]   set_nx;
  logic [CNT_W-1:0]   cnt_nx;

  assign fl_in  = flags_t'(flags_in);
  assign ev_cmp = (op == OP_CMP);
  assign ev_set = (op == OP_SET);

  cmpcc_flag_gen #(.DW(DATA_W)) u_flag (
    .a      (opnd_a),
    .b      (opnd_b),
    .fl     (cmp_fl),
    .borrow (cmp_borrow)
  );

  cmpcc_cond_eval #(.SW(SET_W)) u_cond (
    .cc      (cc),
    .fl      (fl_in),
    .hit     (cond_hit),
    .set_val (set_val)
  );

  cmpcc_loop_ctl #(.CW(CNT_W)) u_loop (
    .op       (op),
    .cnt      (count_in),
    .zf       (fl_in.zf),
    .loop_op  (loop_op),
    .cnt_dec  (cnt_dec),
    .cnt_live (cnt_live),
    .take     (loop_take)
  );

  always_comb begin
    fl_nx  = ev_cmp  ? cmp_fl  : fl_in;
    set_nx = ev_set  ? set_val : '0;
    cnt_nx = loop_op ? cnt_dec : count_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      flags_out   <= '0;
      set_byte    <= '0;
      count_out   <= '0;
      take_branch <= 1'b0;
    end else begin
      out_valid <= op_valid;
      if (op_valid) begin
        flags_out   <= fl_nx;
        set_byte    <= set_nx;
        count_out   <= cnt_nx;
        take_branch <= loop_take;
      end
    end
  end
endmodule

// File: rtl/cmpcc_unit_chk.sv
module cmpcc_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int SET_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op,
  input logic [3:0]        cc,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [3:0]        flags_in,
  input logic [CNT_W-1:0]  count_in,
  input logic              out_valid,
  input logic [3:0]        flags_out,
  input logic [SET_W-1:0]  set_byte,
  input logic [CNT_W-1:0]  count_out,
  input logic              take_branch
);
  logic any_loop;
  assign any_loop = (op == 3'd3) || (op == 3'd4) || (op == 3'd5);

  p_vld_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(op_valid));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> ($stable(flags_out) && $stable(count_out) && $stable(set_byte) && $stable(take_branch)));

  p_cmp_zf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op == 3'd1)) |-> (flags_out[1] == ($past(opnd_a) == $past(opnd_b))));

  p_cmp_cf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op == 3'd1)) |-> (flags_out[0] == ($past(opnd_a) < $past(opnd_b))));

  p_set_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op == 3'd2)) |-> ((set_byte == '0) || (&set_byte)));

  p_bad_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op == 3'd2 && cc >= 4'd10)) |-> (set_byte == '0));

  p_loop_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(any_loop)) |-> (count_out == $past(count_in) - 1'b1));

  p_take_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_branch |-> (count_out != '0));

  p_loope_zf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && take_branch && $past(op == 3'd4)) |-> $past(flags_in[1]));

  p_loopne_zf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && take_branch && $past(op == 3'd5)) |-> !$past(flags_in[1]));

  p_loop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(any_loop)) |-> (flags_out == $past(flags_in)));

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(any_loop && count_in == '0)) |-> (&count_out));

  p_idle_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op == 3'd0 || op >= 3'd6)) |-> (!take_branch && set_byte == '0));
endmodule

bind cmpcc_unit cmpcc_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SET_W(SET_W)) u_chk (.*);

// File: tb/cmpcc_unit_test.sv
`timescale 1ns/1ps
module cmpcc_unit_test;
  localparam int TDW = 8;
  localparam int TCW = 4;
  localparam int TSW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           op_valid = 1'b0;
  logic [2:0]     op = '0;
  logic [3:0]     cc = '0;
  logic [TDW-1:0] opnd_a = '0;
  logic [TDW-1:0] opnd_b = '0;
  logic [3:0]     flags_in = '0;
  logic [TCW-1:0] count_in = '0;
  logic           out_valid;
  logic [3:0]     flags_out;
  logic [TSW-1:0] set_byte;
  logic [TCW-1:0] count_out;
  logic           take_branch;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmpcc_unit #(.DATA_W(TDW), .CNT_W(TCW), .SET_W(TSW)) uut (.*);

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench model: flags from integer arithmetic.
  function automatic logic [3:0] m_cmp(input logic [TDW-1:0] a, input logic [TDW-1:0] b);
    longint ua, ub, sa, sb, sd, lim;
    logic [TDW-1:0] r;
    ua = longint'(a); ub = longint'(b);
    lim = longint'(1) << (TDW - 1);
    sa = (ua >= lim) ? ua - 2*lim : ua;
    sb = (ub >= lim) ? ub - 2*lim : ub;
    sd = sa - sb;
    r  = TDW'(ua - ub);
    return {(sd >= lim) || (sd < -lim), r[TDW-1], (r == '0), (ua < ub)};
  endfunction

  function automatic logic m_cond(input logic [3:0] c, input logic [3:0] f);
    logic cf, zf, sf, of;
    {of, sf, zf, cf} = f;
    case (c)
      4'd0: return zf;
      4'd1: return !zf;
      4'd2: return cf;
      4'd3: return cf || zf;
      4'd4: return !cf && !zf;
      4'd5: return !cf;
      4'd6: return sf != of;
      4'd7: return zf || (sf != of);
      4'd8: return !zf && (sf == of);
      4'd9: return sf == of;
      default: return 1'b0;
    endcase
  endfunction

  // Condition judged directly from operand relations (for compare-then-set).
  function automatic logic m_rel(input logic [3:0] c, input logic [TDW-1:0] a, input logic [TDW-1:0] b);
    logic signed [TDW-1:0] sa, sb;
    sa = a; sb = b;
    case (c)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return a < b;
      4'd3: return a <= b;
      4'd4: return a > b;
      4'd5: return a >= b;
      4'd6: return sa < sb;
      4'd7: return sa <= sb;
      4'd8: return sa > sb;
      4'd9: return sa >= sb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input logic [2:0] o, input logic [3:0] c, input logic [TDW-1:0] a,
                       input logic [TDW-1:0] b, input logic [3:0] f, input logic [TCW-1:0] n);
    @(negedge clk);
    op = o; cc = c; opnd_a = a; opnd_b = b; flags_in = f; count_in = n; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_check(input logic [2:0] o, input logic [3:0] c, input logic [TDW-1:0] a,
                           input logic [TDW-1:0] b, input logic [3:0] f, input logic [TCW-1:0] n);
    logic [3:0] ef;
    logic [TSW-1:0] es;
    logic [TCW-1:0] en;
    logic et;
    string rq;
    ef = f; es = '0; en = n; et = 1'b0;
    case (o)
      3'd1: begin ef = m_cmp(a, b); rq = "R3"; end
      3'd2: begin es = m_cond(c, f) ? '1 : '0; rq = "R5"; end
      3'd3: begin en = n - 1'b1; et = (en != 0); rq = "R6"; end
      3'd4: begin en = n - 1'b1; et = (en != 0) && f[1]; rq = "R7"; end
      3'd5: begin en = n - 1'b1; et = (en != 0) && !f[1]; rq = "R8"; end
      default: rq = "R11";
    endcase
    issue(o, c, a, b, f, n);
    check("R2", "out_valid", 64'(out_valid), 64'(1'b1));
    check((o >= 3'd3 && o <= 3'd5) ? "R9" : rq, "flags_out", 64'(flags_out), 64'(ef));
    check(rq, "set_byte", 64'(set_byte), 64'(es));
    check((o >= 3'd3 && o <= 3'd5 && n == 0) ? "R10" : rq, "count_out", 64'(count_out), 64'(en));
    check(rq, "take_branch", 64'(take_branch), 64'(et));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] keep_f;
    logic [TCW-1:0] keep_n;
    void'($urandom(32'h1cc5));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", 64'(out_valid), 0);
    check("R1", "outputs", 64'({flags_out, set_byte, count_out, take_branch}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release", 64'({out_valid, flags_out, set_byte, count_out, take_branch}), 0);

    // R3: compare corners
    run_check(3'd1, 4'd0, 8'h80, 8'h01, 4'h0, 4'd5);   // signed overflow
    run_check(3'd1, 4'd0, 8'h00, 8'h01, 4'hF, 4'd5);   // borrow
    run_check(3'd1, 4'd0, 8'h5A, 8'h5A, 4'h0, 4'd5);   // equal
    run_check(3'd1, 4'd0, 8'h7F, 8'hFF, 4'h0, 4'd5);   // overflow other way

    // R4: compare then set, each code judged by operand relation
    for (int p = 0; p < 6; p++) begin
      logic [TDW-1:0] xa, xb;
      logic [3:0] fl;
      xa = (p == 0) ? 8'h10 : (p == 1) ? 8'h80 : (p == 2) ? 8'h7F : 8'($urandom);
      xb = (p == 0) ? 8'h10 : (p == 1) ? 8'h7F : (p == 2) ? 8'h80 : 8'($urandom);
      issue(3'd1, 4'd0, xa, xb, 4'h0, 4'd0);
      fl = flags_out;
      for (int c = 0; c < 16; c++) begin
        issue(3'd2, 4'(c), 8'h00, 8'h00, fl, 4'd3);
        check("R4", $sformatf("set cc=%0d", c), 64'(set_byte), m_rel(4'(c), xa, xb) ? 64'hFF : 64'h00);
        check("R5", "set keeps count", 64'(count_out), 64'd3);
      end
    end

    // R6..R10 loop corners
    run_check(3'd3, 4'd0, 8'h00, 8'h00, 4'h5, 4'd1);   // R6: reaches zero, no branch
    run_check(3'd3, 4'd0, 8'h00, 8'h00, 4'hA, 4'd2);   // R6: branch
    run_check(3'd3, 4'd0, 8'h00, 8'h00, 4'h3, 4'd0);   // R10: wrap
    run_check(3'd4, 4'd0, 8'h00, 8'h00, 4'h2, 4'd7);   // R7: zf=1 taken
    run_check(3'd4, 4'd0, 8'h00, 8'h00, 4'h0, 4'd7);   // R7: zf=0 not taken
    run_check(3'd4, 4'd0, 8'h00, 8'h00, 4'h2, 4'd1);   // R7: count zero
    run_check(3'd5, 4'd0, 8'h00, 8'h00, 4'h0, 4'd7);   // R8: zf=0 taken
    run_check(3'd5, 4'd0, 8'h00, 8'h00, 4'h2, 4'd7);   // R8: zf=1 not taken
    run_check(3'd5, 4'd0, 8'h00, 8'h00, 4'hD, 4'd0);   // R10 with R8

    // R11: idle and reserved opcodes
    run_check(3'd0, 4'd2, 8'h12, 8'h34, 4'h9, 4'd6);
    run_check(3'd6, 4'd2, 8'h12, 8'h34, 4'h6, 4'd6);
    run_check(3'd7, 4'd2, 8'h12, 8'h34, 4'hC, 4'd0);

    // R2: outputs hold without op_valid
    keep_f = flags_out; keep_n = count_out;
    @(negedge clk);
    op = 3'd1; opnd_a = 8'h01; opnd_b = 8'h02; flags_in = 4'h0; count_in = 4'd9; op_valid = 1'b0;
    @(negedge clk);
    check("R2", "valid low", 64'(out_valid), 0);
    check("R2", "flags held", 64'(flags_out), 64'(keep_f));
    check("R2", "count held", 64'(count_out), 64'(keep_n));

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [TCW-1:0] n;
      logic [TDW-1:0] a;
      logic [TDW-1:0] b;
      a = 8'($urandom);
      b = ($urandom % 5 == 0) ? a : 8'($urandom);
      n = ($urandom % 4 == 0) ? 4'd0 : ($urandom % 3 == 0) ? 4'd1 : 4'($urandom);
      run_check(3'($urandom), 4'($urandom), a, b, 4'($urandom), n);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule